// File: doc/BRIEF.md
# Set/Clear Register Pair Bank

This block holds a small bank of 32-bit registers that software changes without read-modify-write. Each register is reached at two bus offsets: a write to the set offset turns on the bits that are 1 in the data, and a write to the clear offset turns off the bits that are 1 in the data. All other bits keep their value. Because each write touches only the bits it names, a driver thread and an interrupt handler cannot undo each other's updates.

The bank holds three registers. The first is a general control register. The second is an interrupt event register, whose bits can also be set by hardware event pulses. The third is an interrupt mask register. The interrupt output is high while any event bit is also enabled in the mask. A read of the event register's clear offset returns only the enabled events. A handler can therefore read the pending work and then clear exactly those bits at the same offset.

The register bus is synchronous. A write takes effect at the clock edge where `wr_en` is high. A read is requested with `rd_en`, and the result appears on `rd_data` one cycle later.

Top module: `scb_bank`

## Requirements
- R1: A write to a set offset makes every bit that is 1 in `wr_data` become 1 in that register after the write edge. Bits that are 0 in `wr_data` are left unchanged.
- R2: A write to a clear offset makes every bit that is 1 in `wr_data` become 0 in that register after the write edge. Bits that are 0 in `wr_data` are left unchanged.
- R3: A read of a set offset returns the register value. For the control and mask registers, a read of the clear offset returns the same value as the set offset.
- R4: A read of the event register's clear offset returns the event bits ANDed with the mask bits.
- R5: `addr` is a byte offset. The offsets are: control set 0x50 and clear 0x54, event set 0x80 and clear 0x84, mask set 0x88 and clear 0x8C. The read result is on `rd_data` in the cycle after the edge that sampled `rd_en`, and it reflects the state before that edge. `rd_data` is zero when no read was sampled.
- R6: A read of any other offset returns zero, and this includes misaligned offsets such as 0x81. A write to any other offset changes no register.
- R7: When a bit of `hw_evt` is high at a clock edge, the same bit of the event register is 1 after that edge.
- R8: If a software clear of an event bit and a hardware pulse on that bit happen at the same edge, the bit ends up 1.
- R9: `irq` is 1 exactly when some bit is 1 in both the event register and the mask register. It follows register changes in the cycle after the edge that made them.
- R10: Synchronous active-high `rst` sets all three registers to zero. `irq` is therefore low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data (bit mask for set/clear) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read result, one cycle after rd_en |
| hw_evt | input | 32 | Hardware event pulses, one per event bit |
| irq | output | 1 | Combined interrupt, any enabled pending event |

## Verification
A wrong register bit is visible at the next read of that register, one cycle after the read is requested. If the wrong bit is in the event or mask register, it also shows on `irq` in the cycle right after the bad update. A decode fault shows in two ways. Either a neighbouring register changes after a write, which a read-back exposes, or an unmapped offset returns a non-zero value. The check that the set/clear priority is wrong is made only at the point where a hardware pulse and a software clear reach the same bit in the same cycle. That case is driven on purpose, and the result is read back straight after it.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL_SET = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_CTRL_CLR = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_EVT_SET  = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_EVT_CLR  = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h88;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h8C;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_EVT  = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    // Decoded access: which register, and through which of its two offsets
    typedef struct packed {
        reg_sel_e sel;
        logic     clr_side;
    } acc_t;

    function automatic acc_t decode_offset(input logic [ADDR_W-1:0] a);
        acc_t r;
        r.sel      = SEL_NONE;
        r.clr_side = 1'b0;
        case (a)
            OFS_CTRL_SET: r.sel = SEL_CTRL;
            OFS_CTRL_CLR: begin r.sel = SEL_CTRL; r.clr_side = 1'b1; end
            OFS_EVT_SET:  r.sel = SEL_EVT;
            OFS_EVT_CLR:  begin r.sel = SEL_EVT;  r.clr_side = 1'b1; end
            OFS_MASK_SET: r.sel = SEL_MASK;
            OFS_MASK_CLR: begin r.sel = SEL_MASK; r.clr_side = 1'b1; end
            default:      r.sel = SEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scb_addr_dec.sv
module scb_addr_dec
    import scb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output acc_t              acc,
    output logic              wr_set,
    output logic              wr_clr
);
    always_comb begin
        acc    = decode_offset(addr);
        wr_set = wr_en && (acc.sel != SEL_NONE) && !acc.clr_side;
        wr_clr = wr_en && (acc.sel != SEL_NONE) &&  acc.clr_side;
    end
endmodule

// File: rtl/scb_sc_reg.sv
module scb_sc_reg #(
    parameter int DATA_W = 32,
    parameter bit HW_SET = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              do_set,
    input  logic              do_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] set_m, clr_m, hw_m, nxt;

    generate
        if (HW_SET) begin : g_hw
            assign hw_m = hw_set;
        end else begin : g_nohw
            assign hw_m = '0;
            logic unused_hw;
            assign unused_hw = ^hw_set;
        end
    endgenerate

    always_comb begin
        set_m = (sel && do_set) ? wdata : '0;
        clr_m = (sel && do_clr) ? wdata : '0;
        // Clear is applied first, so any set (software or hardware) wins
        nxt   = (q & ~clr_m) | set_m | hw_m;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/scb_rd_mux.sv
module scb_rd_mux
    import scb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] ctrl_v,
    input  logic [DATA_W-1:0] evt_v,
    input  logic [DATA_W-1:0] mask_v,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sel_v;

    always_comb begin
        case (acc.sel)
            SEL_CTRL: sel_v = ctrl_v;
            SEL_MASK: sel_v = mask_v;
            SEL_EVT:  sel_v = acc.clr_side ? (evt_v & mask_v) : evt_v;
            default:  sel_v = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel_v;
        else            rd_data <= '0;
    end
endmodule

// File: rtl/scb_bank.sv
module scb_bank
    import scb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hw_evt,
    output logic              irq
);
    localparam int NREG = 3;

    acc_t              acc;
    logic              wr_set, wr_clr;
    logic [DATA_W-1:0] ctrl_q, evt_q, mask_q;
    logic [NREG-1:0]   hit;
    logic [DATA_W-1:0] regs_q [NREG];

    scb_addr_dec u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .acc    (acc),
        .wr_set (wr_set),
        .wr_clr (wr_clr)
    );

    assign hit[0] = (acc.sel == SEL_CTRL);
    assign hit[1] = (acc.sel == SEL_EVT);
    assign hit[2] = (acc.sel == SEL_MASK);

    // Register 1 (event) is the only one that takes hardware pulses
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        scb_sc_reg #(
            .DATA_W (DATA_W),
            .HW_SET (i == 1)
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .sel    (hit[i]),
            .do_set (wr_set),
            .do_clr (wr_clr),
            .wdata  (wr_data),
            .hw_set (hw_evt),
            .q      (regs_q[i])
        );
    end

    assign ctrl_q = regs_q[0];
    assign evt_q  = regs_q[1];
    assign mask_q = regs_q[2];

    scb_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .acc     (acc),
        .ctrl_v  (ctrl_q),
        .evt_v   (evt_q),
        .mask_v  (mask_q),
        .rd_data (rd_data)
    );

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk
    import scb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] hw_evt,
    input logic              irq,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] evt_q,
    input logic [DATA_W-1:0] mask_q
);
    logic unmapped;
    assign unmapped = (addr != 8'h50) && (addr != 8'h54) && (addr != 8'h80) &&
                      (addr != 8'h84) && (addr != 8'h88) && (addr != 8'h8C);

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && evt_q == '0 && mask_q == '0 && !irq)); // R10

    AST_SET_EVT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h80) |=> ((evt_q & $past(wr_data)) == $past(wr_data))); // R1

    AST_CLR_CTRL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h54) |=> ((ctrl_q & $past(wr_data)) == '0)); // R2

    AST_HW_SET: assert property (@(posedge clk) disable iff (rst)
        (hw_evt != '0) |=> ((evt_q & $past(hw_evt)) == $past(hw_evt))); // R7

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unmapped) |=> ($stable(ctrl_q) && $stable(mask_q))); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R9
endmodule

bind scb_bank scb_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .hw_evt  (hw_evt),
    .irq     (irq),
    .ctrl_q  (ctrl_q),
    .evt_q   (evt_q),
    .mask_q  (mask_q)
);

// File: tb/scb_bank_test.sv
`timescale 1ns/1ps
module scb_bank_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic [31:0] hw_evt;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // bench model of register contents
    logic [31:0] m_ctrl, m_evt, m_mask;

    always #10 clk = ~clk; // 50 MHz

    scb_bank uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .hw_evt(hw_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write, optionally with hardware pulses in the same cycle
    task automatic wr_hw(input logic [7:0] a, input logic [31:0] d, input logic [31:0] hw);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; hw_evt = hw;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; hw_evt = '0; addr = '0; wr_data = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_hw(a, d, 32'h0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R10 ctrl", 8'h50, 32'h0);
        rd_chk("R10 evt",  8'h80, 32'h0);
        rd_chk("R10 mask", 8'h88, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);
        check("R5 idle rd_data", rd_data, 32'h0);
    endtask

    task automatic t_ctrl();
        wr(8'h50, 32'hF0F0_1234); m_ctrl |= 32'hF0F0_1234;
        rd_chk("R1 ctrl set", 8'h50, m_ctrl);
        wr(8'h50, 32'h0000_0003); m_ctrl |= 32'h3;
        rd_chk("R1 ctrl set keeps", 8'h50, m_ctrl);
        wr(8'h54, 32'h1000_1030); m_ctrl &= ~32'h1000_1030;
        rd_chk("R2 ctrl clear", 8'h50, m_ctrl);
        rd_chk("R3 ctrl clear-side read", 8'h54, m_ctrl);
    endtask

    task automatic t_mask();
        wr(8'h88, 32'h0000_00FF); m_mask |= 32'hFF;
        rd_chk("R3 mask set read", 8'h88, m_mask);
        rd_chk("R3 mask clear read", 8'h8C, m_mask);
        check("R9 irq no events", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_hw_evt();
        @(negedge clk); hw_evt = 32'h0000_0101;
        @(posedge clk); #1;
        check("R9 irq after pulse", {31'h0, irq}, 32'h1);
        @(negedge clk); hw_evt = '0;
        m_evt |= 32'h0000_0101;
        rd_chk("R7 event raw", 8'h80, m_evt);
        rd_chk("R4 event masked", 8'h84, m_evt & m_mask);
    endtask

    task automatic t_conflict();
        wr_hw(8'h84, 32'h0000_0105, 32'h0000_0004);
        m_evt = (m_evt & ~32'h105) | 32'h4;
        rd_chk("R8 set beats clear", 8'h80, m_evt);
        check("R9 irq pending", {31'h0, irq}, 32'h1);
        wr(8'h84, 32'h0000_0004); m_evt &= ~32'h4;
        rd_chk("R2 evt clear", 8'h80, m_evt);
        check("R9 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_sw_evt();
        wr(8'h80, 32'h8000_0000); m_evt |= 32'h8000_0000;
        rd_chk("R1 evt sw set", 8'h80, m_evt);
        rd_chk("R4 masked hides", 8'h84, m_evt & m_mask);
        check("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(8'h88, 32'h8000_0000); m_mask |= 32'h8000_0000;
        check("R9 irq enabled", {31'h0, irq}, 32'h1);
        rd_chk("R4 masked shows", 8'h84, m_evt & m_mask);
        wr(8'h8C, 32'h8000_0000); m_mask &= ~32'h8000_0000;
        rd_chk("R2 mask clear", 8'h88, m_mask);
        check("R9 irq off", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h81, 32'hFFFF_FFFF);
        wr(8'h52, 32'hFFFF_FFFF);
        rd_chk("R6 ctrl kept", 8'h50, m_ctrl);
        rd_chk("R6 evt kept",  8'h80, m_evt);
        rd_chk("R6 mask kept", 8'h88, m_mask);
        rd_chk("R6 read 0x58", 8'h58, 32'h0);
        rd_chk("R6 read 0x81", 8'h81, 32'h0);
        rd_chk("R6 read 0x00", 8'h00, 32'h0);
    endtask

    task automatic t_rereset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        m_ctrl = '0; m_evt = '0; m_mask = '0;
        rd_chk("R10 ctrl after reset", 8'h54, 32'h0);
        rd_chk("R10 mask after reset", 8'h8C, 32'h0);
        check("R10 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; hw_evt = '0;
        m_ctrl = '0; m_evt = '0; m_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_ctrl();
        t_mask();
        t_hw_evt();
        t_conflict();
        t_sw_evt();
        t_unmapped();
        t_rereset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule